// File: doc/BRIEF.md
# Four-Channel Cascadable Interval Timer

The block holds four 16-bit up-counters. Each counter counts either a prescaled version of a shared time base or the overflows of the counter one position below it. Software programs each channel through a write port with a channel select and a reload/control select. It reads a channel's live count together with its control word through a combinational read port. A clock-enable input qualifies every time-base tick.

A channel runs while its enable bit is set. It is armed only by a 0-to-1 change of that bit, which copies the reload value into the counter and clears the channel's prescaler. When the counter steps past 0xFFFF it takes the reload value again. It can then emit a one-cycle interrupt pulse. In cascade mode the overflow also advances the next channel up, through a combinational chain that settles within one cycle.

Top module: `tmr_bank`

## Requirements
- R1: After reset every channel reads count 0x0000 and control 0x0000, and `irq_o` is 0.
- R2: A control write that changes bit 7 from 0 to 1 loads the count from the reload register on that clock edge and clears the channel's prescaler.
- R3: A control write with bit 7 set while the channel already runs updates the control word but does not reload the count; counting continues.
- R4: Control bits [1:0] select the tick period in enabled time-base cycles: 0 gives 1, 1 gives 64, 2 gives 256, 3 gives 1024. The first increment comes one full period after the start edge.
- R5: An increment from 0xFFFF loads the reload value instead of 0x0000.
- R6: With control bit 6 set, `irq_o[ch]` is high for exactly the one cycle after the overflowing edge. With bit 6 clear, no pulse is produced.
- R7: Channels 1 to 3 with bit 2 set (and bit 7 set) ignore the time base and increment once per overflow of the channel below. Channel 0 ignores bit 2 and always counts the time base.
- R8: Clearing bit 7 stops the channel and its count stays frozen.
- R9: A reload write to a running channel leaves the current count untouched and takes effect at the next overflow.
- R10: `rd_data_o[15:0]` is the live count and `rd_data_o[31:16]` the control word of channel `rd_ch_i`.
- R11: While `tick_en_i` is low, no channel increments and no prescaler advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Time-base clock enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | 2 | Channel addressed by the write |
| wr_ctl_i | input | 1 | 1 writes the control word, 0 writes the reload value |
| wr_data_i | input | 16 | Write data |
| rd_ch_i | input | 2 | Channel addressed by the read |
| rd_data_o | output | 32 | {control, live count} of the read channel |
| irq_o | output | 4 | One-cycle overflow interrupt per channel |

## Verification
The bench rewrites the enable bit on a running channel. A design that reloads on level instead of edge would snap the count back to the reload value. It counts cycles exactly at the 63/64 prescale boundary, where a prescaler that is not cleared on start, or that is off by one, lands one count away. It changes the reload value in mid-run to catch a design that copies the new value straight into the count. It also places a cascade on channel 0 and a stopped lower channel under a cascading one, to catch a design that counts the time base in cascade or chains channel 0 to nothing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRESC_W  = 10;
  localparam int CTL_EN   = 7;
  localparam int CTL_IRQ  = 6;
  localparam int CTL_CASC = 2;

  // low bits of the prescaler that must be all ones for a tick
  function automatic logic [PRESC_W-1:0] presc_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    presc_mask = '0;
      2'd1:    presc_mask = PRESC_W'(63);
      2'd2:    presc_mask = PRESC_W'(255);
      default: presc_mask = PRESC_W'(1023);
    endcase
  endfunction
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [PRESC_W-1:0] cnt_q;
  logic [PRESC_W-1:0] mask;

  assign mask   = presc_mask(sel_i);
  assign tick_o = run_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  // R11
  presc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int  CNT_W     = 16,
  parameter bit  HAS_LOWER = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             wr_rld_i,
  input  logic             wr_ctl_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             casc_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] ctl_o,
  output logic             ovf_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] rld_q, ctl_q, cnt_q;
  logic             irq_q;
  logic             en, casc, start, ptick, inc, ovf;

  assign en    = ctl_q[CTL_EN];
  assign casc  = HAS_LOWER && ctl_q[CTL_CASC];
  assign start = wr_ctl_i && !en && wr_data_i[CTL_EN];

  tmr_presc u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .run_i  (en && !casc && tick_en_i),
    .sel_i  (ctl_q[1:0]),
    .tick_o (ptick)
  );

  assign inc = en && (casc ? casc_i : ptick);
  assign ovf = inc && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_q <= '0;
      ctl_q <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_rld_i) rld_q <= wr_data_i;
      if (wr_ctl_i) ctl_q <= wr_data_i;
      if (start || ovf) cnt_q <= rld_q;
      else if (inc)     cnt_q <= cnt_q + 1'b1;
      irq_q <= ovf && ctl_q[CTL_IRQ];
    end
  end

  assign count_o = cnt_q;
  assign ctl_o   = ctl_q;
  assign ovf_o   = ovf;
  assign irq_o   = irq_q;

  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_q[CTL_EN]) |-> cnt_q == $past(rld_q));
  // R6
  irq_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt_q == $past(rld_q));
  // R8
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q[CTL_EN] && $past(!ctl_q[CTL_EN])) |-> $stable(cnt_q));
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!tick_en_i) && $past(ctl_q[CTL_EN]) && ctl_q[CTL_EN]) |-> $stable(cnt_q));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_en_i,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_ch_i,
  input  logic               wr_ctl_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  input  logic [SEL_W-1:0]   rd_ch_i,
  output logic [2*CNT_W-1:0] rd_data_o,
  output logic [NUM_CH-1:0]  irq_o
);
  logic [NUM_CH:0]    chain;
  logic [CNT_W-1:0]   cnt [NUM_CH];
  logic [CNT_W-1:0]   ctl [NUM_CH];

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = wr_en_i && (wr_ch_i == SEL_W'(i));
    tmr_channel #(
      .CNT_W     (CNT_W),
      .HAS_LOWER (i > 0)
    ) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_en_i (tick_en_i),
      .wr_rld_i  (sel && !wr_ctl_i),
      .wr_ctl_i  (sel && wr_ctl_i),
      .wr_data_i (wr_data_i),
      .casc_i    (chain[i]),
      .count_o   (cnt[i]),
      .ctl_o     (ctl[i]),
      .ovf_o     (chain[i+1]),
      .irq_o     (irq_o[i])
    );
  end

  assign rd_data_o = {ctl[rd_ch_i], cnt[rd_ch_i]};

  // R11
  ovf_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chain) |-> tick_en_i);
endmodule

// File: tb/tmr_bank_tb_top.sv
module tmr_bank_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_en_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_ch_i = '0;
  logic        wr_ctl_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  rd_ch_i = '0;
  logic [31:0] rd_data_o;
  logic [3:0]  irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  tmr_bank dut_i (.*);

  localparam int VN = 7;
  localparam int V_DIV [VN] = '{0, 1, 1, 2, 3, 0, 2};
  localparam int V_RLD [VN] = '{'h1000, 0, 0, 'h10, 'hFFF0, 'hFFFE, 'hFFFF};
  localparam int V_CYC [VN] = '{10, 63, 64, 512, 2048, 3, 256};
  localparam int V_EXP [VN] = '{'h100A, 0, 1, 'h12, 'hFFF2, 'hFFFF, 'hFFFF};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the capturing edge
  task automatic wr(input int ch, input bit is_ctl, input logic [15:0] d);
    wr_en_i = 1'b1; wr_ch_i = 2'(ch); wr_ctl_i = is_ctl; wr_data_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int ch, output logic [31:0] v);
    rd_ch_i = 2'(ch); #1; v = rd_data_o;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a;
    logic        seen;
    repeat (3) @(negedge clk_i);
    for (int c = 0; c < 4; c++) begin
      rd(c, v); chk("R1 reset read", v, 32'h0);
    end
    chk("R1 reset irq", {28'h0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table: prescale and wrap on channel 0
    for (int k = 0; k < VN; k++) begin
      wr(0, 1, 16'h0);
      wr(0, 0, 16'(V_RLD[k]));
      wr(0, 1, 16'(16'h80 | V_DIV[k]));
      wait_cyc(V_CYC[k]);
      rd(0, v);
      chk((k >= 5) ? "R5 wrap reload" : "R4 prescale count", {16'h0, v[15:0]}, 32'(V_EXP[k]));
    end
    wr(0, 1, 16'h0);

    // R2 start load visible right after start edge
    wr(0, 0, 16'h4321);
    wr(0, 1, 16'h0083);
    rd(0, v); chk("R2 start load", {16'h0, v[15:0]}, 32'h4321);
    wr(0, 1, 16'h0);

    // R9 reload change while running
    wr(0, 0, 16'hFFF0);
    wr(0, 1, 16'h0080);
    wr(0, 0, 16'hA000);
    rd(0, v); chk("R9 count untouched", {16'h0, v[15:0]}, 32'hFFF1);
    wait_cyc(15);
    rd(0, v); chk("R9 next reload", {16'h0, v[15:0]}, 32'hA000);
    wr(0, 1, 16'h0);

    // R6 interrupt pulse
    wr(1, 0, 16'hFFFE);
    wr(1, 1, 16'h00C0);
    chk("R6 no irq before ovf", {28'h0, irq_o}, 32'h0);
    wait_cyc(2);
    chk("R6 irq pulse", {28'h0, irq_o}, 32'h2);
    wait_cyc(1);
    chk("R6 irq one cycle", {28'h0, irq_o}, 32'h0);
    wr(1, 1, 16'h0);
    wr(1, 1, 16'h0080);
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      wait_cyc(1); seen |= irq_o[1];
    end
    chk("R6 masked irq", {31'h0, seen}, 32'h0);
    wr(1, 1, 16'h0);

    // R7 cascade
    wr(1, 0, 16'h0005);
    wr(1, 1, 16'h0084);
    wait_cyc(5);
    rd(1, v); chk("R7 cascade idle", {16'h0, v[15:0]}, 32'h5);
    wr(0, 0, 16'hFFFC);
    wr(0, 1, 16'h0080);
    wait_cyc(8);
    rd(1, v); chk("R7 cascade count", {16'h0, v[15:0]}, 32'h7);
    rd(0, v); chk("R7 lower reload", {16'h0, v[15:0]}, 32'hFFFC);
    wr(0, 1, 16'h0);
    wr(1, 1, 16'h0);
    wr(0, 0, 16'h0);
    wr(0, 1, 16'h0084);
    wait_cyc(3);
    rd(0, v); chk("R7 ch0 ignores cascade", {16'h0, v[15:0]}, 32'h3);
    wr(0, 1, 16'h0);

    // R11 clock enable gating
    wr(2, 0, 16'h0020);
    wr(2, 1, 16'h0080);
    wait_cyc(4);
    tick_en_i = 1'b0;
    wait_cyc(10);
    rd(2, v); chk("R11 hold without tick", {16'h0, v[15:0]}, 32'h24);
    tick_en_i = 1'b1;

    // R8 stop freezes
    wr(2, 1, 16'h0);
    rd(2, a); chk("R8 stop value", {16'h0, a[15:0]}, 32'h25);
    wait_cyc(10);
    rd(2, v); chk("R8 frozen", v, a);

    // R3 re-enable while running, R10 packed read
    wr(3, 0, 16'h0100);
    wr(3, 1, 16'h0080);
    wait_cyc(5);
    wr(3, 1, 16'h0080);
    rd(3, v);
    chk("R3 no reload on rewrite", {16'h0, v[15:0]}, 32'h106);
    chk("R10 packed read", v, 32'h0080_0106);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule